// File: doc/BRIEF.md
# Static Branch Predictor with Fetch Redirect

This block picks the address that instruction fetch uses next in a five-stage in-order pipeline. Each cycle it receives the current fetch address, the instruction class, the branch condition code, the instruction length and the encoded target. From these it forms a prediction of the next address. Three static policies are available, and a mode input chooses one at run time: every conditional branch taken; every conditional branch not taken; or backward branches taken and forward branches not taken. Unconditional jumps and calls always go to their target.

For every conditional branch it predicts, the block stores the prediction, the condition code and the address it did not choose. The store is a short queue whose depth matches the distance from fetch to execute. When the branch reaches execute, the block evaluates its condition from the zero, sign and overflow flags supplied in that cycle. If the outcome disagrees with the prediction, the block raises a mispredict, presents the stored alternate address as the corrected address, and drops the younger branch records from the wrong path. Returns make no prediction. When the return address read from memory is offered, it becomes the next fetch address, unless a redirect is active in the same cycle.

Top module: `brpred_nextpc`

## Requirements
- R1: After reset, no branch record is held, `mispredict` is low, and `next_pc` follows the prediction for the current inputs.
- R2: For a class of 0 (non-branch), or for the unused classes 5 to 7, `next_pc` is `f_pc` plus the zero-extended `f_len`, taken modulo 2^64.
- R3: Class 2 (unconditional jump), class 3 (call), and class 1 with condition code 0 all give `f_target` in every mode, and they create no record.
- R4: Mode encodings are 0 = always-taken, 1 = not-taken and 2 = backward-taken/forward-not-taken; mode 3 behaves as mode 0. In mode 0, a class 1 branch with a nonzero condition code predicts `f_target`.
- R5: In mode 1, a class 1 branch with a nonzero condition code predicts the sequential address `f_pc + f_len`.
- R6: In mode 2, a class 1 branch with a nonzero condition code predicts `f_target` when `f_target` is less than the sequential address in an unsigned compare. Otherwise, including when the two are equal, it predicts the sequential address.
- R7: Condition codes evaluate as follows: 1 = ZF or (SF xor OF); 2 = SF xor OF; 3 = ZF; 4 = not ZF; 5 = not (SF xor OF); 6 = not (SF xor OF) and not ZF. Code 7 is never true.
- R8: A class 1 branch with a nonzero code, fetched with `f_valid` high in cycle c, is resolved in cycle c+2 using `e_zf`, `e_sf` and `e_of` of that cycle. If the outcome differs from the prediction, `mispredict` is high in that cycle and `corrected_pc` is the address that was not predicted.
- R9: In a mispredict cycle, the records of the two younger branches (the one fetched in the previous cycle and the one fetched in that same cycle) are discarded and never cause a mispredict. `mispredict` is never high in two consecutive cycles.
- R10: `next_pc` is `corrected_pc` when `mispredict` is high; otherwise it is `ret_addr` when `ret_valid` is high; otherwise it is the prediction.
- R11: Class 4 (return) and cycles with `f_valid` low create no record. With `ret_valid` low, a return's `next_pc` is the sequential address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Prediction policy select |
| f_valid | input | 1 | A real instruction is in fetch this cycle |
| f_class | input | 3 | Instruction class code |
| f_cond | input | 3 | Branch condition code |
| f_pc | input | 64 | Address of the instruction in fetch |
| f_len | input | 4 | Instruction length in bytes |
| f_target | input | 64 | Jump or call target |
| e_zf | input | 1 | Zero flag seen by execute |
| e_sf | input | 1 | Sign flag seen by execute |
| e_of | input | 1 | Overflow flag seen by execute |
| ret_valid | input | 1 | Return address from memory is present |
| ret_addr | input | 64 | Return address from memory |
| next_pc | output | 64 | Address fetch uses next |
| mispredict | output | 1 | Branch in execute went the other way |
| corrected_pc | output | 64 | Alternate address of the branch in execute |

## Verification
The main function is driven with directed patterns for each policy. Targets placed below, above and equal to the sequential address separate backward from forward in the third policy and show the equal case is treated as forward. Every condition code is run against all eight flag combinations under the taken policy, so a mispredict appears exactly where the condition is false; this distinguishes each equation from its neighbours. Back-to-back branches behind a mispredicting one confirm that wrong-path records are dropped. Colliding return and redirect cycles confirm the priority order, and a long randomized mix with short-distance targets covers class, mode and flag interactions.

// File: rtl/bp_pkg.sv
package bp_pkg;

   typedef enum logic [2:0] {
      CLS_OTHER = 3'd0,
      CLS_CJMP  = 3'd1,
      CLS_UJMP  = 3'd2,
      CLS_CALL  = 3'd3,
      CLS_RET   = 3'd4
   } iclass_e;

   typedef enum logic [1:0] {
      POL_TAKEN    = 2'd0,
      POL_NOTTAKEN = 2'd1,
      POL_BTFNT    = 2'd2
   } policy_e;

   localparam logic [2:0] CC_ALWAYS = 3'd0;
   localparam logic [2:0] CC_LE     = 3'd1;
   localparam logic [2:0] CC_LT     = 3'd2;
   localparam logic [2:0] CC_EQ     = 3'd3;
   localparam logic [2:0] CC_NE     = 3'd4;
   localparam logic [2:0] CC_GE     = 3'd5;
   localparam logic [2:0] CC_GT     = 3'd6;

endpackage

// File: rtl/bp_cond_eval.sv
module bp_cond_eval
   import bp_pkg::*;
(
   input  logic [2:0] cc,
   input  logic       zf,
   input  logic       sf,
   input  logic       of,
   output logic       holds
);

   logic lt;

   always_comb begin
      lt = sf ^ of;
      case (cc)
         CC_ALWAYS: holds = 1'b1;
         CC_LE:     holds = lt | zf;
         CC_LT:     holds = lt;
         CC_EQ:     holds = zf;
         CC_NE:     holds = ~zf;
         CC_GE:     holds = ~lt;
         CC_GT:     holds = ~lt & ~zf;
         default:   holds = 1'b0;
      endcase
   end

endmodule

// File: rtl/bp_predict.sv
module bp_predict
   import bp_pkg::*;
#(
   parameter int AW = 64,
   parameter int LW = 4
) (
   input  logic          f_valid,
   input  logic [2:0]    cls,
   input  logic [2:0]    cc,
   input  logic [1:0]    mode,
   input  logic [AW-1:0] pc,
   input  logic [LW-1:0] len,
   input  logic [AW-1:0] target,
   output logic [AW-1:0] pred_pc,
   output logic          rec_en,
   output logic          rec_taken,
   output logic [AW-1:0] rec_alt
);

   localparam int PAD = AW - LW;

   logic [AW-1:0] len_ext;
   logic [AW-1:0] seq_pc;
   logic          backward;
   logic          dir_taken;
   logic          taken;

   generate
      if (PAD > 0) begin : g_pad
         assign len_ext = {{PAD{1'b0}}, len};
      end else begin : g_nopad
         assign len_ext = len[AW-1:0];
      end
   endgenerate

   assign seq_pc   = pc + len_ext;
   assign backward = target < seq_pc;

   always_comb begin
      case (mode)
         POL_NOTTAKEN: dir_taken = 1'b0;
         POL_BTFNT:    dir_taken = backward;
         default:      dir_taken = 1'b1;
      endcase
   end

   always_comb begin
      taken  = 1'b0;
      rec_en = 1'b0;
      case (cls)
         CLS_CJMP: begin
            if (cc == CC_ALWAYS) begin
               taken = 1'b1;
            end else begin
               taken  = dir_taken;
               rec_en = f_valid;
            end
         end
         CLS_UJMP, CLS_CALL: taken = 1'b1;
         default:            taken = 1'b0;
      endcase
   end

   assign pred_pc   = taken ? target : seq_pc;
   assign rec_taken = taken;
   assign rec_alt   = taken ? seq_pc : target;

endmodule

// File: rtl/bp_resolve_q.sv
module bp_resolve_q #(
   parameter int AW    = 64,
   parameter int DEPTH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          push_taken,
   input  logic [2:0]    push_cc,
   input  logic [AW-1:0] push_alt,
   output logic          head_valid,
   output logic          head_taken,
   output logic [2:0]    head_cc,
   output logic [AW-1:0] head_alt
);

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         logic          v_q;
         logic          t_q;
         logic [2:0]    c_q;
         logic [AW-1:0] a_q;
         logic          v_d;
         logic          t_d;
         logic [2:0]    c_d;
         logic [AW-1:0] a_d;

         if (i == 0) begin : g_head_in
            assign v_d = push;
            assign t_d = push_taken;
            assign c_d = push_cc;
            assign a_d = push_alt;
         end else begin : g_chain_in
            assign v_d = g_stage[i-1].v_q;
            assign t_d = g_stage[i-1].t_q;
            assign c_d = g_stage[i-1].c_q;
            assign a_d = g_stage[i-1].a_q;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               t_q <= 1'b0;
               c_q <= '0;
               a_q <= '0;
            end else begin
               v_q <= v_d & ~flush;
               t_q <= t_d;
               c_q <= c_d;
               a_q <= a_d;
            end
         end
      end
   endgenerate

   assign head_valid = g_stage[DEPTH-1].v_q;
   assign head_taken = g_stage[DEPTH-1].t_q;
   assign head_cc    = g_stage[DEPTH-1].c_q;
   assign head_alt   = g_stage[DEPTH-1].a_q;

endmodule

// File: rtl/brpred_nextpc.sv
module brpred_nextpc #(
   parameter int AW        = 64,
   parameter int LW        = 4,
   parameter int RES_DEPTH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode,
   input  logic          f_valid,
   input  logic [2:0]    f_class,
   input  logic [2:0]    f_cond,
   input  logic [AW-1:0] f_pc,
   input  logic [LW-1:0] f_len,
   input  logic [AW-1:0] f_target,
   input  logic          e_zf,
   input  logic          e_sf,
   input  logic          e_of,
   input  logic          ret_valid,
   input  logic [AW-1:0] ret_addr,
   output logic [AW-1:0] next_pc,
   output logic          mispredict,
   output logic [AW-1:0] corrected_pc
);

   generate
      if (AW < 8) begin : g_bad_aw
         $error("brpred_nextpc: AW must be at least 8");
      end
      if (LW < 1 || LW >= AW) begin : g_bad_lw
         $error("brpred_nextpc: LW must be in 1..AW-1");
      end
      if (RES_DEPTH < 1) begin : g_bad_depth
         $error("brpred_nextpc: RES_DEPTH must be at least 1");
      end
   endgenerate

   logic [AW-1:0] pred_pc;
   logic          rec_en;
   logic          rec_taken;
   logic [AW-1:0] rec_alt;
   logic          hd_valid;
   logic          hd_taken;
   logic [2:0]    hd_cc;
   logic [AW-1:0] hd_alt;
   logic          cond_true;

   bp_predict #(.AW(AW), .LW(LW)) u_pred (
      .f_valid   (f_valid),
      .cls       (f_class),
      .cc        (f_cond),
      .mode      (mode),
      .pc        (f_pc),
      .len       (f_len),
      .target    (f_target),
      .pred_pc   (pred_pc),
      .rec_en    (rec_en),
      .rec_taken (rec_taken),
      .rec_alt   (rec_alt)
   );

   bp_resolve_q #(.AW(AW), .DEPTH(RES_DEPTH)) u_q (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (mispredict),
      .push       (rec_en),
      .push_taken (rec_taken),
      .push_cc    (f_cond),
      .push_alt   (rec_alt),
      .head_valid (hd_valid),
      .head_taken (hd_taken),
      .head_cc    (hd_cc),
      .head_alt   (hd_alt)
   );

   bp_cond_eval u_cc (
      .cc    (hd_cc),
      .zf    (e_zf),
      .sf    (e_sf),
      .of    (e_of),
      .holds (cond_true)
   );

   assign mispredict   = hd_valid & (cond_true != hd_taken);
   assign corrected_pc = hd_valid ? hd_alt : '0;

   always_comb begin
      if (mispredict)     next_pc = corrected_pc;
      else if (ret_valid) next_pc = ret_addr;
      else                next_pc = pred_pc;
   end

endmodule

// File: rtl/brpred_nextpc_chk.sv
module brpred_nextpc_chk #(
   parameter int AW = 64,
   parameter int LW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    mode,
   input logic          f_valid,
   input logic [2:0]    f_class,
   input logic [2:0]    f_cond,
   input logic [AW-1:0] f_pc,
   input logic [LW-1:0] f_len,
   input logic [AW-1:0] f_target,
   input logic          ret_valid,
   input logic [AW-1:0] ret_addr,
   input logic [AW-1:0] next_pc,
   input logic          mispredict,
   input logic [AW-1:0] corrected_pc
);

   logic [AW-1:0] seq;
   logic          quiet;
   logic          cbr;
   assign seq   = f_pc + AW'(f_len);
   assign quiet = !mispredict && !ret_valid;
   assign cbr   = f_valid && (f_class == 3'd1) && (f_cond != 3'd0);

   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> !mispredict);

   a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && f_class == 3'd0) |-> next_pc == seq);

   a_r3_uncond_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && (f_class == 3'd2 || f_class == 3'd3)) |-> next_pc == f_target);

   a_r5_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && cbr && mode == 2'd1) |-> next_pc == seq);

   a_r6_forward_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && cbr && mode == 2'd2 && f_target >= seq) |-> next_pc == seq);

   a_r9_no_double_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      mispredict |=> !mispredict);

   a_r10_redirect_wins: assert property (@(posedge clk) disable iff (!rst_n)
      mispredict |-> next_pc == corrected_pc);

   a_r10_return_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (!mispredict && ret_valid) |-> next_pc == ret_addr);

endmodule

bind brpred_nextpc brpred_nextpc_chk #(.AW(AW), .LW(LW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode         (mode),
   .f_valid      (f_valid),
   .f_class      (f_class),
   .f_cond       (f_cond),
   .f_pc         (f_pc),
   .f_len        (f_len),
   .f_target     (f_target),
   .ret_valid    (ret_valid),
   .ret_addr     (ret_addr),
   .next_pc      (next_pc),
   .mispredict   (mispredict),
   .corrected_pc (corrected_pc)
);

// File: tb/brpred_nextpc_bench.sv
`timescale 1ns/1ps
module brpred_nextpc_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic        f_valid = 1'b0;
   logic [2:0]  f_class = 3'd0;
   logic [2:0]  f_cond = 3'd0;
   logic [63:0] f_pc = 64'd0;
   logic [3:0]  f_len = 4'd0;
   logic [63:0] f_target = 64'd0;
   logic        e_zf = 1'b0, e_sf = 1'b0, e_of = 1'b0;
   logic        ret_valid = 1'b0;
   logic [63:0] ret_addr = 64'd0;
   logic [63:0] next_pc;
   logic        mispredict;
   logic [63:0] corrected_pc;

   int vectors = 0;
   int fails = 0;
   bit done = 0;

   // reference state: two pending branches, index 1 is the one at execute
   bit          m_v [2];
   bit          m_t [2];
   logic [2:0]  m_c [2];
   logic [63:0] m_a [2];

   always #4 clk = ~clk;

   brpred_nextpc u_brpred_nextpc (
      .clk(clk), .rst_n(rst_n), .mode(mode), .f_valid(f_valid),
      .f_class(f_class), .f_cond(f_cond), .f_pc(f_pc), .f_len(f_len),
      .f_target(f_target), .e_zf(e_zf), .e_sf(e_sf), .e_of(e_of),
      .ret_valid(ret_valid), .ret_addr(ret_addr), .next_pc(next_pc),
      .mispredict(mispredict), .corrected_pc(corrected_pc));

   function automatic bit ref_cond(input logic [2:0] c, input bit z, input bit s, input bit o);
      bit less;
      less = (s != o);
      if (c == 3'd0) return 1;
      if (c == 3'd1) return less || z;
      if (c == 3'd2) return less;
      if (c == 3'd3) return z;
      if (c == 3'd4) return !z;
      if (c == 3'd5) return !less;
      if (c == 3'd6) return !less && !z;
      return 0;
   endfunction

   function automatic bit ref_taken();
      logic [63:0] s;
      s = f_pc + {60'd0, f_len};
      if (f_class == 3'd2 || f_class == 3'd3) return 1;
      if (f_class != 3'd1) return 0;
      if (f_cond == 3'd0) return 1;
      if (mode == 2'd1) return 0;
      if (mode == 2'd2) return f_target < s;
      return 1;
   endfunction

   task automatic model_clear();
      for (int i = 0; i < 2; i++) begin
         m_v[i] = 0; m_t[i] = 0; m_c[i] = 3'd0; m_a[i] = 64'd0;
      end
   endtask

   task automatic step(input string tag);
      logic [63:0] s, pred, exp_pc;
      bit tk, exp_mis;
      #1;
      s    = f_pc + {60'd0, f_len};
      tk   = ref_taken();
      pred = tk ? f_target : s;
      exp_mis = m_v[1] && (ref_cond(m_c[1], e_zf, e_sf, e_of) != m_t[1]);
      if (exp_mis) exp_pc = m_a[1];
      else if (ret_valid) exp_pc = ret_addr;
      else exp_pc = pred;
      vectors++;
      if (mispredict !== exp_mis) begin
         fails++;
         $display("FAIL %s mispredict actual=%0b expected=%0b", tag, mispredict, exp_mis);
      end
      if (next_pc !== exp_pc) begin
         fails++;
         $display("FAIL %s next_pc actual=%h expected=%h", tag, next_pc, exp_pc);
      end
      if (exp_mis && corrected_pc !== m_a[1]) begin
         fails++;
         $display("FAIL %s corrected_pc actual=%h expected=%h", tag, corrected_pc, m_a[1]);
      end
      if (exp_mis) begin
         model_clear();
      end else begin
         m_v[1] = m_v[0]; m_t[1] = m_t[0]; m_c[1] = m_c[0]; m_a[1] = m_a[0];
         m_v[0] = f_valid && f_class == 3'd1 && f_cond != 3'd0;
         m_t[0] = tk;
         m_c[0] = f_cond;
         m_a[0] = tk ? s : f_target;
      end
      @(negedge clk);
   endtask

   task automatic put(input logic [2:0] cls, input logic [2:0] cc,
                      input logic [63:0] pc, input logic [3:0] len, input logic [63:0] tgt);
      f_valid = 1'b1; f_class = cls; f_cond = cc; f_pc = pc; f_len = len; f_target = tgt;
   endtask

   task automatic filler();
      put(3'd0, 3'd0, 64'h4000, 4'd1, 64'h0);
   endtask

   function automatic string rand_tag();
      bit exp_mis;
      exp_mis = m_v[1] && (ref_cond(m_c[1], e_zf, e_sf, e_of) != m_t[1]);
      if (exp_mis) return "R8";
      if (ret_valid) return "R10";
      if (f_class == 3'd4) return "R11";
      if (f_class == 3'd2 || f_class == 3'd3) return "R3";
      if (f_class != 3'd1) return "R2";
      if (mode == 2'd1) return "R5";
      if (mode == 2'd2) return "R6";
      return "R4";
   endfunction

   initial begin
      #800000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      put(3'd0, 3'd0, 64'h1000, 4'd10, 64'h0);
      step("R1");
      // R2: sequential and wraparound, unused class
      put(3'd0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFE, 4'd3, 64'h55);
      step("R2");
      put(3'd6, 3'd2, 64'h2000, 4'd9, 64'h10);
      step("R2");
      // R3: unconditional transfers in every mode
      for (int md = 0; md < 4; md++) begin
         mode = md[1:0];
         put(3'd2, 3'd0, 64'h3000, 4'd9, 64'h100);  step("R3");
         put(3'd3, 3'd0, 64'h3000, 4'd9, 64'h9000); step("R3");
         put(3'd1, 3'd0, 64'h3000, 4'd9, 64'h20);   step("R3");
      end
      // R4/R5/R6: conditional branches below, above and equal to fall-through
      e_zf = 1'b1;
      for (int md = 0; md < 4; md++) begin
         mode = md[1:0];
         put(3'd1, 3'd3, 64'h5000, 4'd9, 64'h4000); step(md == 1 ? "R5" : md == 2 ? "R6" : "R4");
         put(3'd1, 3'd3, 64'h5000, 4'd9, 64'h6000); step(md == 1 ? "R5" : md == 2 ? "R6" : "R4");
         put(3'd1, 3'd3, 64'h5000, 4'd9, 64'h5009); step(md == 1 ? "R5" : md == 2 ? "R6" : "R4");
         filler(); step("R8");
         filler(); step("R8");
      end
      // R7: every condition code against every flag combination
      mode = 2'd0;
      for (int cc = 1; cc < 8; cc++) begin
         for (int fl = 0; fl < 8; fl++) begin
            {e_zf, e_sf, e_of} = fl[2:0];
            put(3'd1, cc[2:0], 64'h7000, 4'd9, 64'h7100); step("R7");
            filler(); step("R7");
            filler(); step("R7");
         end
      end
      // R9: mispredict drops the two younger branches
      mode = 2'd0; {e_zf, e_sf, e_of} = 3'b000;
      put(3'd1, 3'd3, 64'h8000, 4'd9, 64'h8800); step("R9");
      put(3'd1, 3'd3, 64'h8800, 4'd9, 64'h8900); step("R9");
      put(3'd1, 3'd3, 64'h8900, 4'd9, 64'h8A00); step("R9");
      filler(); step("R9");
      filler(); step("R9");
      // R11: invalid fetch and return create no record
      f_valid = 1'b0; f_class = 3'd1; f_cond = 3'd3; step("R11");
      put(3'd4, 3'd0, 64'hA000, 4'd1, 64'h0); step("R11");
      filler(); step("R11");
      filler(); step("R11");
      // R10: return address vs redirect priority
      put(3'd4, 3'd0, 64'hB000, 4'd1, 64'h0);
      ret_valid = 1'b1; ret_addr = 64'hDEAD_BEEF_0000_1234; step("R10");
      ret_valid = 1'b0;
      put(3'd1, 3'd4, 64'hC000, 4'd9, 64'hC100); e_zf = 1'b1; step("R10");
      filler(); step("R10");
      ret_valid = 1'b1; put(3'd4, 3'd0, 64'hC200, 4'd1, 64'h0); step("R10");
      ret_valid = 1'b0;
      // randomized mix
      for (int n = 0; n < 4000; n++) begin
         logic [63:0] pc;
         logic [63:0] tgt;
         int sel;
         pc  = {$urandom, $urandom};
         sel = $urandom_range(0, 3);
         tgt = (sel == 0) ? {$urandom, $urandom} : pc + 64'($signed($urandom_range(0, 64)) - 32);
         mode = 2'($urandom_range(0, 3));
         f_valid = ($urandom_range(0, 7) != 0);
         f_class = 3'($urandom_range(0, 7) < 4 ? 1 : $urandom_range(0, 7));
         f_cond = 3'($urandom_range(0, 7));
         f_pc = pc; f_len = 4'($urandom_range(1, 10)); f_target = tgt;
         {e_zf, e_sf, e_of} = 3'($urandom_range(0, 7));
         ret_valid = ($urandom_range(0, 15) == 0);
         ret_addr = {$urandom, $urandom};
         step(rand_tag());
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule